// File: doc/BRIEF.md
# Chip-Select Space and Interrupt-Level Qualifier

This block decides, on every bus cycle, whether one programmable chip-select line goes active. It receives the address space of the current cycle, an interrupt-acknowledge flag, the three address bits that carry the acknowledged interrupt level, and a hit signal from an external base-address comparator. It compares these against a set of option fields: a 2-bit space selector, a 3-bit level selector and an autovector enable.

In CPU space the block qualifies only interrupt-acknowledge cycles. It can filter them down to one interrupt level. When the autovector enable is set, it also raises an autovector request. That request is withheld whenever the chip select runs in synchronous mode.

Both outputs are registered. They follow the address strobe: they assert on the first clock edge that sees the strobe low on a qualified cycle, and they clear on the edge after the strobe goes high. The option fields are sampled only while the strobe is idle. A change made during a cycle therefore waits for the next cycle.

Top module: `cs_iack_match`

## Requirements
- R1: After reset, and while reset is held, `cs_n` is 1 and `avec_req` is 0. The held option values reset to space 00, level 000, autovector off.
- R2: Both `opt_space` and `cyc_space` use this encoding: 00 CPU, 01 user, 10 supervisor. For `opt_space` only, 11 means user or supervisor. With space 01, 10 or 11, a non-acknowledge cycle whose space is included asserts the chip select; any other space does not.
- R3: With `opt_space` 00, an acknowledge cycle (`iack`=1, `cyc_space`=00) asserts the chip select when `ack_level` equals a nonzero `opt_level`.
- R4: `opt_level` 000 matches any acknowledged level (000 through 111).
- R5: With `opt_space` 00 and a nonzero `opt_level` that differs from `ack_level`, the chip select stays deasserted.
- R6: With `opt_space` 00, a CPU-space cycle with `iack`=0 never asserts the chip select. With space 01, 10 or 11, an acknowledge cycle never asserts it.
- R7: When `base_hit` is 0, no cycle asserts the chip select.
- R8: `avec_req` is 1 only together with an asserted chip select, only with `opt_space` 00 and `opt_autovec` 1. With `opt_autovec` 0 it stays 0.
- R9: When `sync_mode` is 1, `avec_req` stays 0, and the chip-select decision is unchanged.
- R10: Outputs are registered. On a qualified cycle they take their active value at the first rising edge that samples `as_n` low, and hold it while the strobe stays low. They return to inactive at the first rising edge that samples `as_n` high.
- R11: The option inputs are captured at each rising edge that samples `as_n` high. Changes made while the strobe is low have no effect until the next bus cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| as_n | input | 1 | Address strobe, active low; low marks a bus cycle |
| cyc_space | input | 2 | Address space of the current cycle (00 CPU, 01 user, 10 supervisor) |
| iack | input | 1 | Current cycle is an interrupt acknowledge |
| ack_level | input | 3 | Acknowledged interrupt level from address bits 3:1 |
| base_hit | input | 1 | External base-address comparator match |
| sync_mode | input | 1 | Chip select operates in synchronous mode |
| opt_space | input | 2 | Space option field |
| opt_level | input | 3 | Interrupt level option field (000 = any) |
| opt_autovec | input | 1 | Autovector enable |
| cs_n | output | 1 | Chip select, active low, registered |
| avec_req | output | 1 | Autovector request, registered |

## Verification
Suppose the held option register holds a stale or corrupted value. The first bus cycle after the corruption then decodes the wrong space or level. The fault shows on `cs_n` one clock after the strobe falls. A register that fails to clear shows a chip select or autovector request that outlasts the strobe by more than one clock edge. A fault in the sync-mode or autovector gating shows as `avec_req` going high on the same edge as `cs_n` where it must stay low.

// File: rtl/cs_match_pkg.sv
package cs_match_pkg;

  localparam int SPACE_W = 2;
  localparam int LVL_W   = 3;
  localparam logic [LVL_W-1:0] ANY_LEVEL = '0;

  typedef enum logic [SPACE_W-1:0] {
    SP_CPU   = 2'b00,
    SP_USER  = 2'b01,
    SP_SUPER = 2'b10,
    SP_BOTH  = 2'b11
  } space_e;

  typedef struct packed {
    space_e            space;
    logic [LVL_W-1:0]  level;
    logic              autovec;
  } opt_t;

  localparam opt_t OPT_RESET = '{space: SP_CPU, level: ANY_LEVEL, autovec: 1'b0};

endpackage

// File: rtl/cs_opt_hold.sv
module cs_opt_hold
  import cs_match_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic as_n,
  input  opt_t opt_in,
  output opt_t opt_act
);

  opt_t act_q;

  // Options are sampled only between bus cycles
  always_ff @(posedge clk) begin
    if (!rst_n)    act_q <= OPT_RESET;
    else if (as_n) act_q <= opt_in;
  end

  assign opt_act = act_q;

  // R11: held options frozen while the strobe is active
  a_r11_opts_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !as_n |=> $stable(act_q));

endmodule

// File: rtl/cs_qualify.sv
module cs_qualify
  import cs_match_pkg::*;
(
  input  opt_t             opt,
  input  logic [SPACE_W-1:0] cyc_space,
  input  logic             iack,
  input  logic [LVL_W-1:0] ack_level,
  input  logic             base_hit,
  input  logic             sync_mode,
  output logic             sel,
  output logic             avec
);

  logic space_ok;
  logic level_ok;
  logic is_user, is_super, is_cpu;

  assign is_cpu   = (cyc_space == SPACE_W'(SP_CPU));
  assign is_user  = (cyc_space == SPACE_W'(SP_USER));
  assign is_super = (cyc_space == SPACE_W'(SP_SUPER));

  always_comb begin
    case (opt.space)
      SP_CPU:   space_ok = iack && is_cpu;
      SP_USER:  space_ok = !iack && is_user;
      SP_SUPER: space_ok = !iack && is_super;
      SP_BOTH:  space_ok = !iack && (is_user || is_super);
      default:  space_ok = 1'b0;
    endcase
  end

  // Level filter applies to CPU-space acknowledge decoding only
  assign level_ok = (opt.space != SP_CPU) || (opt.level == ANY_LEVEL) ||
                    (opt.level == ack_level);

  assign sel  = space_ok && level_ok && base_hit;
  assign avec = sel && (opt.space == SP_CPU) && opt.autovec && !sync_mode;

endmodule

// File: rtl/cs_out_reg.sv
module cs_out_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic as_n,
  input  logic sel,
  input  logic avec,
  output logic cs_n,
  output logic avec_req
);

  logic cs_n_q, avec_q;

  always_ff @(posedge clk) begin
    if (!rst_n || as_n) begin
      cs_n_q <= 1'b1;
      avec_q <= 1'b0;
    end else begin
      cs_n_q <= !sel;
      avec_q <= avec;
    end
  end

  assign cs_n     = cs_n_q;
  assign avec_req = avec_q;

  // R10: idle strobe clears both outputs on the next edge
  a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
    as_n |=> (cs_n_q && !avec_q));

  // R8: autovector request never without the chip select
  a_r8_avec_with_cs: assert property (@(posedge clk) disable iff (!rst_n)
    avec_q |-> !cs_n_q);

endmodule

// File: rtl/cs_iack_match.sv
module cs_iack_match
  import cs_match_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       as_n,
  input  logic [1:0] cyc_space,
  input  logic       iack,
  input  logic [2:0] ack_level,
  input  logic       base_hit,
  input  logic       sync_mode,
  input  logic [1:0] opt_space,
  input  logic [2:0] opt_level,
  input  logic       opt_autovec,
  output logic       cs_n,
  output logic       avec_req
);

  opt_t opt_in, opt_act;
  logic sel, avec;

  assign opt_in = '{space: space_e'(opt_space), level: opt_level, autovec: opt_autovec};

  cs_opt_hold u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .as_n    (as_n),
    .opt_in  (opt_in),
    .opt_act (opt_act)
  );

  cs_qualify u_qual (
    .opt       (opt_act),
    .cyc_space (cyc_space),
    .iack      (iack),
    .ack_level (ack_level),
    .base_hit  (base_hit),
    .sync_mode (sync_mode),
    .sel       (sel),
    .avec      (avec)
  );

  cs_out_reg u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .as_n     (as_n),
    .sel      (sel),
    .avec     (avec),
    .cs_n     (cs_n),
    .avec_req (avec_req)
  );

  // R1: outputs inactive on the first edge out of reset
  a_r1_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (cs_n && !avec_req));

  // R9: synchronous mode blocks the autovector request
  a_r9_sync_no_avec: assert property (@(posedge clk) disable iff (!rst_n)
    sync_mode |=> !avec_req);

  // R7: no base hit, no chip select
  a_r7_need_hit: assert property (@(posedge clk) disable iff (!rst_n)
    !base_hit |=> cs_n);

  // R5: level mismatch on acknowledge blocks the chip select
  a_r5_level_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (!as_n && opt_act.space == SP_CPU && opt_act.level != ANY_LEVEL &&
     opt_act.level != ack_level) |=> cs_n);

  // R6: acknowledge cycles never match a user/supervisor setting
  a_r6_iack_space: assert property (@(posedge clk) disable iff (!rst_n)
    (iack && opt_act.space != SP_CPU) |=> cs_n);

endmodule

// File: tb/sim_cs_iack_match.sv
`timescale 1ns/1ps
module sim_cs_iack_match;

  logic clk = 1'b0;
  logic rst_n, as_n, iack, base_hit, sync_mode, opt_autovec;
  logic [1:0] cyc_space, opt_space;
  logic [2:0] ack_level, opt_level;
  logic cs_n, avec_req;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  cs_iack_match u0 (
    .clk(clk), .rst_n(rst_n), .as_n(as_n), .cyc_space(cyc_space), .iack(iack),
    .ack_level(ack_level), .base_hit(base_hit), .sync_mode(sync_mode),
    .opt_space(opt_space), .opt_level(opt_level), .opt_autovec(opt_autovec),
    .cs_n(cs_n), .avec_req(avec_req)
  );

  // {opt_space, opt_level, opt_autovec, cyc_space, iack, ack_level, hit, sync, exp_cs, exp_avec}
  localparam int N = 24;
  localparam logic [15:0] TBL [0:N-1] = '{
    {2'b01,3'd0,1'b0, 2'b01,1'b0,3'd0,1'b1,1'b0, 1'b1,1'b0}, // R2 user
    {2'b01,3'd0,1'b0, 2'b10,1'b0,3'd0,1'b1,1'b0, 1'b0,1'b0}, // R2
    {2'b10,3'd0,1'b0, 2'b10,1'b0,3'd0,1'b1,1'b0, 1'b1,1'b0}, // R2 super
    {2'b10,3'd0,1'b0, 2'b01,1'b0,3'd0,1'b1,1'b0, 1'b0,1'b0}, // R2
    {2'b11,3'd0,1'b0, 2'b01,1'b0,3'd0,1'b1,1'b0, 1'b1,1'b0}, // R2 both
    {2'b11,3'd0,1'b0, 2'b10,1'b0,3'd0,1'b1,1'b0, 1'b1,1'b0}, // R2
    {2'b11,3'd0,1'b0, 2'b00,1'b0,3'd0,1'b1,1'b0, 1'b0,1'b0}, // R2
    {2'b00,3'd3,1'b0, 2'b00,1'b1,3'd3,1'b1,1'b0, 1'b1,1'b0}, // R3
    {2'b00,3'd7,1'b0, 2'b00,1'b1,3'd7,1'b1,1'b0, 1'b1,1'b0}, // R3
    {2'b00,3'd0,1'b0, 2'b00,1'b1,3'd5,1'b1,1'b0, 1'b1,1'b0}, // R4
    {2'b00,3'd0,1'b0, 2'b00,1'b1,3'd1,1'b1,1'b0, 1'b1,1'b0}, // R4
    {2'b00,3'd4,1'b0, 2'b00,1'b1,3'd2,1'b1,1'b0, 1'b0,1'b0}, // R5
    {2'b00,3'd1,1'b0, 2'b00,1'b1,3'd7,1'b1,1'b0, 1'b0,1'b0}, // R5
    {2'b00,3'd0,1'b0, 2'b00,1'b0,3'd0,1'b1,1'b0, 1'b0,1'b0}, // R6
    {2'b01,3'd0,1'b0, 2'b00,1'b1,3'd0,1'b1,1'b0, 1'b0,1'b0}, // R6
    {2'b10,3'd0,1'b0, 2'b00,1'b1,3'd4,1'b1,1'b0, 1'b0,1'b0}, // R6
    {2'b01,3'd0,1'b0, 2'b01,1'b0,3'd0,1'b0,1'b0, 1'b0,1'b0}, // R7
    {2'b00,3'd2,1'b0, 2'b00,1'b1,3'd2,1'b0,1'b0, 1'b0,1'b0}, // R7
    {2'b00,3'd2,1'b1, 2'b00,1'b1,3'd2,1'b1,1'b0, 1'b1,1'b1}, // R8
    {2'b00,3'd0,1'b1, 2'b00,1'b1,3'd6,1'b1,1'b0, 1'b1,1'b1}, // R8
    {2'b00,3'd5,1'b1, 2'b00,1'b1,3'd4,1'b1,1'b0, 1'b0,1'b0}, // R8
    {2'b01,3'd0,1'b1, 2'b01,1'b0,3'd0,1'b1,1'b0, 1'b1,1'b0}, // R8
    {2'b00,3'd2,1'b1, 2'b00,1'b1,3'd2,1'b1,1'b1, 1'b1,1'b0}, // R9
    {2'b00,3'd0,1'b0, 2'b00,1'b1,3'd3,1'b1,1'b1, 1'b1,1'b0}  // R9
  };

  task automatic chk(input string tag, input logic [1:0] exp);
    logic [1:0] act;
    act = {~cs_n, avec_req};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {cs_active,avec_req} actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic set_opts(input logic [1:0] sp, input logic [2:0] lv, input logic av);
    opt_space = sp; opt_level = lv; opt_autovec = av;
  endtask

  task automatic set_cyc(input logic [1:0] sp, input logic ia, input logic [2:0] lv,
                         input logic hit, input logic sy);
    cyc_space = sp; iack = ia; ack_level = lv; base_hit = hit; sync_mode = sy;
  endtask

  initial begin
    rst_n = 1'b0; as_n = 1'b1;
    set_opts(2'b01, 3'd0, 1'b1);
    set_cyc(2'b01, 1'b0, 3'd0, 1'b1, 1'b0);
    repeat (3) @(negedge clk);
    chk("R1 during reset", 2'b00);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", 2'b00);

    // Table walk: options set while idle, cycle run, outputs sampled, strobe released
    for (int i = 0; i < N; i++) begin
      logic [15:0] v;
      v = TBL[i];
      set_opts(v[15:14], v[13:11], v[10]);
      as_n = 1'b1;
      @(negedge clk);
      set_cyc(v[9:8], v[7], v[6:4], v[3], v[2]);
      as_n = 1'b0;
      @(negedge clk);
      chk($sformatf("table row %0d (R2..R9 per row comment)", i), v[1:0]);
      as_n = 1'b1;
      @(negedge clk);
    end

    // R10: timing of assert, hold and release
    set_opts(2'b00, 3'd6, 1'b1);
    @(negedge clk);
    set_cyc(2'b00, 1'b1, 3'd6, 1'b1, 1'b0);
    chk("R10 before strobe", 2'b00);
    as_n = 1'b0;
    @(negedge clk);
    chk("R10 first edge", 2'b11);
    @(negedge clk);
    chk("R10 held", 2'b11);
    as_n = 1'b1;
    @(negedge clk);
    chk("R10 released", 2'b00);

    // R11: option change mid-cycle waits for the next cycle
    set_opts(2'b01, 3'd0, 1'b0);
    @(negedge clk);
    set_cyc(2'b01, 1'b0, 3'd0, 1'b1, 1'b0);
    as_n = 1'b0;
    @(negedge clk);
    chk("R11 match before change", 2'b10);
    set_opts(2'b10, 3'd0, 1'b0);
    @(negedge clk);
    @(negedge clk);
    chk("R11 change ignored mid-cycle", 2'b10);
    as_n = 1'b1;
    @(negedge clk);
    as_n = 1'b0;
    @(negedge clk);
    chk("R11 change applied next cycle", 2'b00);
    as_n = 1'b1;
    @(negedge clk);

    // R1: reset mid-cycle clears outputs and held options
    set_opts(2'b00, 3'd0, 1'b1);
    @(negedge clk);
    set_cyc(2'b00, 1'b1, 3'd2, 1'b1, 1'b0);
    as_n = 1'b0;
    @(negedge clk);
    chk("R8 autovec before reset", 2'b11);
    rst_n = 1'b0;
    set_opts(2'b01, 3'd0, 1'b0);
    @(negedge clk);
    chk("R1 reset mid-cycle", 2'b00);
    rst_n = 1'b1;
    @(negedge clk);
    // strobe still low: held options are the reset values (CPU, any level, no autovec)
    chk("R1 reset option values", 2'b10);
    as_n = 1'b1;
    @(negedge clk);
    chk("R10 release after reset", 2'b00);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule